// File: doc/BRIEF.md
# NAND 1-bit Hamming Parity Generator

This block builds a single-error-correcting parity code over the data words that pass between a memory controller and a NAND flash device with an 8-bit or 16-bit bus. Four chip selects are served, and each one keeps its own accumulator, its own word counter and its own run flag. Software arms one chip select with a start command. That command clears the chip select's accumulator and word counter. From then on, every valid data word on that chip select folds into the code. The chip select must be in NAND mode for this to happen.

The code is a set of twelve parity pairs. Pair k covers the stream bit address of each data bit. That address is the word count since start multiplied by the bus width, plus the bit index within the word. The odd term of pair k is the XOR of every data bit whose stream address has bit k set. The even term is the XOR of every data bit where bit k is clear. With an 8-bit bus, the low three pairs come from the bit index (columns) and the upper nine come from the word count (rows). With a 16-bit bus, four pairs are columns and eight are rows. A result read clears the chip select's run flag. The stored code then stays frozen until the next start.

Top module: `nand_hamming_ecc`

## Requirements
- R1: A start command (`startReq` with `startCs`) sets that chip select's run flag, clears its 28-bit code to zero and resets its word counter to zero at the next edge. Other chip selects are unaffected.
- R2: A result read (`readReq` with `readCs`) clears that chip select's run flag at the next edge. The code stays unchanged afterwards, even if further data words arrive.
- R3: With `dataWide`=0, a word accumulates `dataWord[7:0]`. Bit j of word n has stream address n*8+j. Pair k (k=0..11) XORs the bit into its odd term when address bit k is 1, and into its even term otherwise. Bits 15:8 have no effect.
- R4: With `dataWide`=1, all 16 bits accumulate. Bit j of word n has stream address n*16+j, and the same pair rule applies.
- R5: A data word accumulates only when `dataValid` is high, the chip select has its `nandMode` bit set and its run flag is high. Otherwise the code and the word counter do not change.
- R6: In each chip select's 28-bit slice (`eccCode[cs*28 +: 28]`), the odd term of pair k sits at bit 16+k and the even term at bit k. Bits 15:12 are zero.
- R7: Each chip select keeps its own code, word counter and run flag. Traffic on one chip select never alters another.
- R8: The word counter wraps after 512 bytes: after 512 words with an 8-bit bus, or 256 words with a 16-bit bus. The next word is weighted like word 0.
- R9: A start on the same chip select and in the same cycle as a data word or a read takes priority. The word is dropped and the run flag ends up set.
- R10: After reset, all codes and all run flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nandMode | input | 4 | Per chip select: 1 = NAND device attached |
| dataValid | input | 1 | A data word is on `dataWord` this cycle |
| dataCs | input | 2 | Chip select of the data word |
| dataWide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| dataWord | input | 16 | Data word |
| startReq | input | 1 | Start command |
| startCs | input | 2 | Chip select to start |
| readReq | input | 1 | Result read |
| readCs | input | 2 | Chip select whose result is read |
| eccCode | output | 112 | Four 28-bit codes, chip select 0 in the low slice |
| eccBusy | output | 4 | Run flag per chip select |

## Verification
The bench builds the block with its default parameters: four chip selects, a 16-bit data path, twelve parity pairs and a 9-bit word counter. With these values, a full 512-byte page is only 512 or 256 words. That makes the counter wrap in both bus widths cheap enough to drive directly and to compare against a hand-derived code. A mixed stream across all four chip selects in both widths is checked against a model that works from stream bit addresses rather than a column/row split.

// File: rtl/nhe_pkg.sv
package nhe_pkg;
  localparam int CS_NUM  = 4;
  localparam int CS_W    = $clog2(CS_NUM);
  localparam int DATA_W  = 16;
  localparam int COL_MAX = $clog2(DATA_W);
  localparam int ROW_W   = 9;
  localparam int PAIRS   = ROW_W + COL_MAX - 1;
  localparam int CODE_W  = 28;

  typedef struct packed {
    logic [CS_NUM-1:0] clr;
    logic [CS_NUM-1:0] acc;
    logic [ROW_W-1:0]  row;
  } eccStrobe_t;
endpackage

// File: rtl/nhe_ctrl.sv
module nhe_ctrl
  import nhe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CS_NUM-1:0] nandMode,
  input  logic              dataValid,
  input  logic [CS_W-1:0]   dataCs,
  input  logic              startReq,
  input  logic [CS_W-1:0]   startCs,
  input  logic              readReq,
  input  logic [CS_W-1:0]   readCs,
  output eccStrobe_t        strb,
  output logic [CS_NUM-1:0] busy
);
  logic [CS_NUM-1:0] busyQ;
  logic [ROW_W-1:0]  rowQ [CS_NUM];
  logic [CS_NUM-1:0] startHit, readHit, dataHit;

  always_comb begin
    for (int i = 0; i < CS_NUM; i++) begin
      startHit[i] = startReq && (startCs == CS_W'(i));
      readHit[i]  = readReq && (readCs == CS_W'(i));
      dataHit[i]  = dataValid && (dataCs == CS_W'(i)) && nandMode[i]
                    && busyQ[i] && !startHit[i];
    end
  end

  always_comb begin
    strb.clr = startHit;
    strb.acc = dataHit;
    strb.row = rowQ[dataCs];
  end

  assign busy = busyQ;

  always_ff @(posedge clk) begin
    for (int i = 0; i < CS_NUM; i++) begin
      if (!rstN) begin
        busyQ[i] <= 1'b0;
        rowQ[i]  <= '0;
      end else if (startHit[i]) begin
        busyQ[i] <= 1'b1;
        rowQ[i]  <= '0;
      end else begin
        if (readHit[i]) busyQ[i] <= 1'b0;
        if (dataHit[i]) rowQ[i] <= rowQ[i] + ROW_W'(1);
      end
    end
  end

  AST_START_SETS: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> busy[$past(startCs)]); // R1

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    readReq && !(startReq && startCs == readCs) |=> !busy[$past(readCs)]); // R2

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rstN)
    dataValid && nandMode[dataCs] && busyQ[dataCs] && !(startReq && startCs == dataCs)
    |=> rowQ[$past(dataCs)] == $past(rowQ[dataCs]) + ROW_W'(1)); // R8

  AST_ONE_ACC: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.acc)); // R7
endmodule

// File: rtl/nhe_datapath.sv
module nhe_datapath
  import nhe_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  eccStrobe_t               strb,
  input  logic                     dataWide,
  input  logic [DATA_W-1:0]        dataWord,
  output logic [CS_NUM*CODE_W-1:0] eccCode
);
  localparam int GAP_W = CODE_W - 2 * PAIRS;

  logic [PAIRS-1:0]   oddQ  [CS_NUM];
  logic [PAIRS-1:0]   evenQ [CS_NUM];
  logic [PAIRS-1:0]   oddTerm, evenTerm;
  logic [COL_MAX-1:0] colOdd, colEven;
  logic [PAIRS-1:0]   colOddX, colEvenX, rowAddr;
  logic               wordPar;
  int                 colBits;

  // column parities and whole-word parity for the active bus width
  always_comb begin
    colOdd  = '0;
    colEven = '0;
    wordPar = 1'b0;
    for (int j = 0; j < DATA_W; j++) begin
      if (dataWide || j < DATA_W / 2) begin
        wordPar ^= dataWord[j];
        for (int b = 0; b < COL_MAX; b++) begin
          if (((j >> b) & 1) != 0) colOdd[b]  ^= dataWord[j];
          else                     colEven[b] ^= dataWord[j];
        end
      end
    end
  end

  // merge columns with the word counter into one stream address
  always_comb begin
    colOddX  = PAIRS'(colOdd);
    colEvenX = PAIRS'(colEven);
    colBits  = dataWide ? COL_MAX : COL_MAX - 1;
    rowAddr  = dataWide ? {strb.row[ROW_W-2:0], {COL_MAX{1'b0}}}
                        : {strb.row, {(COL_MAX-1){1'b0}}};
    for (int k = 0; k < PAIRS; k++) begin
      if (k < colBits) begin
        oddTerm[k]  = colOddX[k];
        evenTerm[k] = colEvenX[k];
      end else begin
        oddTerm[k]  = rowAddr[k] & wordPar;
        evenTerm[k] = ~rowAddr[k] & wordPar;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < CS_NUM; i++) begin
      if (!rstN || strb.clr[i]) begin
        oddQ[i]  <= '0;
        evenQ[i] <= '0;
      end else if (strb.acc[i]) begin
        oddQ[i]  <= oddQ[i] ^ oddTerm;
        evenQ[i] <= evenQ[i] ^ evenTerm;
      end
    end
  end

  for (genvar g = 0; g < CS_NUM; g++) begin : gSlice
    assign eccCode[g*CODE_W +: CODE_W] = {oddQ[g], {GAP_W{1'b0}}, evenQ[g]};

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      strb.clr[g] |=> (oddQ[g] == '0 && evenQ[g] == '0)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !strb.clr[g] && !strb.acc[g] |=> $stable(oddQ[g]) && $stable(evenQ[g])); // R5

    AST_PAIR_BALANCE: assert property (@(posedge clk) disable iff (!rstN)
      ((oddQ[g] ^ evenQ[g]) == '0) || ((oddQ[g] ^ evenQ[g]) == '1)); // R3
  end
endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc
  import nhe_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [CS_NUM-1:0]        nandMode,
  input  logic                     dataValid,
  input  logic [CS_W-1:0]          dataCs,
  input  logic                     dataWide,
  input  logic [DATA_W-1:0]        dataWord,
  input  logic                     startReq,
  input  logic [CS_W-1:0]          startCs,
  input  logic                     readReq,
  input  logic [CS_W-1:0]          readCs,
  output logic [CS_NUM*CODE_W-1:0] eccCode,
  output logic [CS_NUM-1:0]        eccBusy
);
  eccStrobe_t strb;

  nhe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .nandMode(nandMode),
    .dataValid(dataValid), .dataCs(dataCs),
    .startReq(startReq), .startCs(startCs),
    .readReq(readReq), .readCs(readCs),
    .strb(strb), .busy(eccBusy)
  );

  nhe_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .dataWide(dataWide), .dataWord(dataWord),
    .eccCode(eccCode)
  );
endmodule

// File: tb/nand_hamming_ecc_bench.sv
`timescale 1ns/1ps
module nand_hamming_ecc_bench;
  logic         clk = 1'b0;
  logic         rstN;
  logic [3:0]   nandMode;
  logic         dataValid, dataWide, startReq, readReq;
  logic [1:0]   dataCs, startCs, readCs;
  logic [15:0]  dataWord;
  logic [111:0] eccCode;
  logic [3:0]   eccBusy;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  logic [11:0] mOdd [4];
  logic [11:0] mEven [4];
  int          mRow [4];
  logic [3:0]  mBusy;

  localparam logic [18:0] VEC [16] = '{
    {2'd0, 1'b0, 16'h00A5}, {2'd2, 1'b1, 16'h1234}, {2'd1, 1'b0, 16'h0081},
    {2'd3, 1'b1, 16'hFFFF}, {2'd0, 1'b0, 16'h003C}, {2'd2, 1'b1, 16'h8001},
    {2'd1, 1'b0, 16'hAB7E}, {2'd3, 1'b1, 16'h0F0F}, {2'd0, 1'b0, 16'h0001},
    {2'd2, 1'b1, 16'hC35A}, {2'd1, 1'b0, 16'h0010}, {2'd3, 1'b1, 16'h4000},
    {2'd0, 1'b0, 16'h00FF}, {2'd2, 1'b1, 16'h0002}, {2'd1, 1'b0, 16'h0066},
    {2'd3, 1'b1, 16'h9999}
  };

  always #4 clk = ~clk;

  nand_hamming_ecc u_nand_hamming_ecc (
    .clk(clk), .rstN(rstN), .nandMode(nandMode),
    .dataValid(dataValid), .dataCs(dataCs), .dataWide(dataWide), .dataWord(dataWord),
    .startReq(startReq), .startCs(startCs), .readReq(readReq), .readCs(readCs),
    .eccCode(eccCode), .eccBusy(eccBusy)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [27:0] slice(input int cs);
    return eccCode[cs*28 +: 28];
  endfunction

  function automatic logic [27:0] mCode(input int cs);
    return {mOdd[cs], 4'b0000, mEven[cs]};
  endfunction

  // reference model by stream bit address
  task automatic modelWord(input int cs, input logic w, input logic [15:0] d);
    int wb = w ? 16 : 8;
    int r  = w ? (mRow[cs] % 256) : (mRow[cs] % 512);
    for (int j = 0; j < wb; j++) begin
      int a = r * wb + j;
      if (d[j]) begin
        for (int k = 0; k < 12; k++) begin
          if (((a >> k) & 1) != 0) mOdd[cs][k]  = ~mOdd[cs][k];
          else                     mEven[cs][k] = ~mEven[cs][k];
        end
      end
    end
    mRow[cs]++;
  endtask

  task automatic step(input logic v, input logic [1:0] dcs, input logic w, input logic [15:0] d,
                      input logic st, input logic [1:0] scs, input logic rd, input logic [1:0] rcs);
    dataValid = v; dataCs = dcs; dataWide = w; dataWord = d;
    startReq = st; startCs = scs; readReq = rd; readCs = rcs;
    if (v && !(st && scs == dcs) && mBusy[dcs] && nandMode[dcs]) modelWord(dcs, w, d);
    if (rd && !(st && scs == rcs)) mBusy[rcs] = 1'b0;
    if (st) begin
      mBusy[scs] = 1'b1; mOdd[scs] = '0; mEven[scs] = '0; mRow[scs] = 0;
    end
    @(posedge clk);
    @(negedge clk);
    dataValid = 1'b0; startReq = 1'b0; readReq = 1'b0;
  endtask

  task automatic word(input logic [1:0] cs, input logic w, input logic [15:0] d);
    step(1'b1, cs, w, d, 1'b0, 2'd0, 1'b0, 2'd0);
  endtask

  task automatic start(input logic [1:0] cs);
    step(1'b0, 2'd0, 1'b0, 16'h0, 1'b1, cs, 1'b0, 2'd0);
  endtask

  task automatic rdRes(input logic [1:0] cs);
    step(1'b0, 2'd0, 1'b0, 16'h0, 1'b0, 2'd0, 1'b1, cs);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired before the run completed");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; nandMode = 4'b1111;
    dataValid = 1'b0; dataCs = '0; dataWide = 1'b0; dataWord = '0;
    startReq = 1'b0; startCs = '0; readReq = 1'b0; readCs = '0;
    mBusy = '0;
    for (int i = 0; i < 4; i++) begin mOdd[i] = '0; mEven[i] = '0; mRow[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R10: reset state
    chk("R10 codes after reset", 64'(eccCode[63:0]), 64'h0);
    chk("R10 upper codes after reset", 64'(eccCode[111:64]), 64'h0);
    chk("R10 busy after reset", 64'(eccBusy), 64'h0);

    // table walk over all four selects, both widths (R3 R4 R6 R7)
    for (int i = 0; i < 4; i++) start(2'(i));
    chk("R1 all started", 64'(eccBusy), 64'hF);
    for (int i = 0; i < 16; i++) word(VEC[i][18:17], VEC[i][16], VEC[i][15:0]);
    for (int i = 0; i < 4; i++) chk("R7 table code per select", 64'(slice(i)), 64'(mCode(i)));

    // R3 R6 hand-derived narrow code
    start(2'd0);
    chk("R1 code cleared on start", 64'(slice(0)), 64'h0);
    word(2'd0, 1'b0, 16'h0001);
    chk("R3 bit at address 0", 64'(slice(0)), 64'h0000FFF);
    word(2'd0, 1'b0, 16'h0080);
    chk("R6 address 15 layout", 64'(slice(0)), 64'h00F000F);

    // R4 hand-derived wide code
    start(2'd2);
    word(2'd2, 1'b1, 16'h8000);
    chk("R4 wide bit 15", 64'(slice(2)), 64'h00F0FF0);

    // R3 upper byte ignored in narrow mode
    start(2'd1);
    word(2'd1, 1'b0, 16'hFF00);
    chk("R3 upper byte ignored", 64'(slice(1)), 64'h0);

    // R2 read clears busy and freezes code
    rdRes(2'd2);
    chk("R2 busy cleared by read", 64'(eccBusy[2]), 64'h0);
    word(2'd2, 1'b1, 16'h0001);
    chk("R2 code frozen after read", 64'(slice(2)), 64'h00F0FF0);

    // R5 select not in NAND mode
    nandMode = 4'b1110;
    start(2'd0);
    word(2'd0, 1'b0, 16'h0001);
    chk("R5 non-NAND select ignored", 64'(slice(0)), 64'h0);
    nandMode = 4'b1111;
    word(2'd0, 1'b0, 16'h0001);
    chk("R5 counter held while non-NAND", 64'(slice(0)), 64'h0000FFF);

    // R9 start wins over data and read on the same select
    step(1'b1, 2'd3, 1'b1, 16'h0001, 1'b1, 2'd3, 1'b0, 2'd0);
    chk("R9 start drops same-cycle word", 64'(slice(3)), 64'h0);
    step(1'b0, 2'd0, 1'b0, 16'h0, 1'b1, 2'd3, 1'b1, 2'd3);
    chk("R9 start wins over read", 64'(eccBusy[3]), 64'h1);

    // R8 wrap, narrow: 512 zero words then a word at row 0 again
    start(2'd0);
    for (int i = 0; i < 512; i++) word(2'd0, 1'b0, 16'h0000);
    word(2'd0, 1'b0, 16'h0001);
    chk("R8 narrow wrap after 512 words", 64'(slice(0)), 64'h0000FFF);

    // R8 wrap, wide: 256 zero words
    start(2'd2);
    for (int i = 0; i < 256; i++) word(2'd2, 1'b1, 16'h0000);
    word(2'd2, 1'b1, 16'h8000);
    chk("R8 wide wrap after 256 words", 64'(slice(2)), 64'h00F0FF0);

    // R7 select 1 untouched by all of the above
    chk("R7 select 1 independent", 64'(slice(1)), 64'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule